// File: doc/BRIEF.md
# CD Subcode Serial Readout Port

This block holds one subcode byte per EFM frame and lets an external reader shift it out bit by bit with a clock that the reader drives itself. A frame strobe from the upstream demodulator delivers the byte together with a flag that marks the two sync frames at the head of each 98-frame block (96 data frames follow them). Frames arrive at 7.35 kHz, so a block lasts 1/75 s. The strobe latches the byte and opens a readout window. During the window a frame-sync output is held low. The reader waits roughly 10 µs into the window, then clocks the bits out. It must finish before the window closes, which is about half of the 136 µs frame.

The serial line presents the P bit first. Each rising edge of the reader's clock moves the line on through Q, R, S, T, U, V and W. If the reader sends more than seven pulses, the sequence starts again at P. A separate block-mark output is high during the two sync frames and otherwise carries the P bit. The reader's clock is asynchronous to the block. It passes through a synchronizer chain and an edge detector before it reaches the bit counter.

A small state machine runs the window. It has two states. WIN_IDLE keeps the frame-sync output high. WIN_OPEN keeps it low and counts the window length down. Its transitions are: open (any state to WIN_OPEN on a frame strobe, which also reloads the timer), close (WIN_OPEN to WIN_IDLE when the timer reaches zero with no strobe), and hold (no change otherwise).

Top module: `subq_port`

## Requirements
- R1: After reset the frame-sync output `win_n` is 1, and both `rd_data` and `blk_mark` are 0.
- R2: A frame strobe drives `win_n` low from the next clock edge. It stays low for exactly WIN_CYC cycles and then returns high.
- R3: The strobe latches `frm_byte` as the outgoing byte, with bit 7 = P, bit 6 = Q, down to bit 0 = W. `rd_data` then presents P.
- R4: Each rising edge of `rd_clk` inside the window moves `rd_data` to the next bit in P, Q, R, S, T, U, V, W order. The new bit appears within SYNC_STAGES+1 clock cycles.
- R5: After the eighth rising edge in one frame, `rd_data` shows P again and the 8-bit sequence repeats.
- R6: `blk_mark` is 1 when the latched sync flag is set. Otherwise it equals the P bit (bit 7) of the latched byte.
- R7: Changes on `frm_byte` or `frm_is_sync` with no strobe have no effect on `rd_data` or `blk_mark`.
- R8: Rising edges of `rd_clk` while `win_n` is high are ignored, and the bit position holds.
- R9: A strobe that arrives during a readout latches the new byte and restarts the sequence at P.
- R10: Falling edges of `rd_clk` do not advance the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_stb | input | 1 | One-cycle strobe, one per EFM frame |
| frm_byte | input | SUB_W | Subcode byte; MSB is P, LSB is W |
| frm_is_sync | input | 1 | Marks a block sync frame (S0 or S1) |
| rd_clk | input | 1 | Reader-driven shift clock, asynchronous |
| win_n | output | 1 | Frame sync; low while the readout window is open |
| blk_mark | output | 1 | High on sync frames, else the P bit |
| rd_data | output | 1 | Serial subcode bit for the reader |

## Verification
The bench builds the block with WIN_CYC = 120, SYNC_STAGES = 2 and SUB_W = 8. The short window lets the bench count the exact window length cycle by cycle. It also leaves room for a full eight-pulse readout, the wrap back to P, and a further pulse beyond it, all inside a single window. Pulses sent after the window closes, a strobe that interrupts a readout, and input changes made with no strobe can each be run in a few hundred cycles.

// File: rtl/subq_pkg.sv
package subq_pkg;
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;
endpackage

// File: rtl/subq_edge_sync.sv
module subq_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[SYNC_STAGES-1];
    end

    assign rise = chain[SYNC_STAGES-1] & ~last_q;

    // R4 / R10: one pulse per rising edge, never two cycles in a row
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/subq_win_fsm.sv
module subq_win_fsm
    import subq_pkg::*;
#(
    parameter int WIN_CYC = 2303
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_stb,
    output logic win_open
);
    localparam int TMR_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WIN_CYC - 1);

    win_state_t       state, state_nx;
    logic [TMR_W-1:0] tmr, tmr_nx;

    always_comb begin
        state_nx = state;
        tmr_nx   = tmr;
        unique case (state)
            WIN_IDLE: begin
                if (frm_stb) begin
                    state_nx = WIN_OPEN;
                    tmr_nx   = TMR_LOAD;
                end
            end
            WIN_OPEN: begin
                if (frm_stb) begin
                    tmr_nx = TMR_LOAD;
                end else if (tmr == '0) begin
                    state_nx = WIN_IDLE;
                end else begin
                    tmr_nx = tmr - 1'b1;
                end
            end
            default: state_nx = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WIN_IDLE;
            tmr   <= '0;
        end else begin
            state <= state_nx;
            tmr   <= tmr_nx;
        end
    end

    always_comb begin
        win_open = (state == WIN_OPEN);
    end

    assert_strobe_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb |=> (state == WIN_OPEN) && (tmr == TMR_LOAD));
    assert_timer_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WIN_OPEN && tmr == '0 && !frm_stb) |=> (state == WIN_IDLE));
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WIN_IDLE && !frm_stb) |=> (state == WIN_IDLE));
endmodule

// File: rtl/subq_shifter.sv
module subq_shifter #(
    parameter int SUB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_stb,
    input  logic [SUB_W-1:0] frm_byte,
    input  logic             frm_is_sync,
    input  logic             win_open,
    input  logic             shift_rise,
    output logic             rd_data,
    output logic             blk_mark
);
    localparam int CNT_W = $clog2(SUB_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SUB_W - 1);

    logic [SUB_W-1:0] byte_q;
    logic             sync_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            sync_q <= 1'b0;
            cnt    <= '0;
        end else if (frm_stb) begin
            byte_q <= frm_byte;
            sync_q <= frm_is_sync;
            cnt    <= '0;
        end else if (win_open && shift_rise) begin
            cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        idx      = CNT_LAST - cnt;
        rd_data  = byte_q[idx];
        blk_mark = sync_q | byte_q[SUB_W-1];
    end

    assert_latch_at_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb |=> (cnt == '0) && (byte_q == $past(frm_byte)));
    assert_step_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && shift_rise && !frm_stb) |=>
            (cnt == (($past(cnt) == CNT_LAST) ? '0 : $past(cnt) + 1'b1)));
    assert_ignore_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !frm_stb) |=> $stable(cnt));
    assert_no_stray_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |=> ($stable(byte_q) && $stable(sync_q)));
endmodule

// File: rtl/subq_port.sv
module subq_port #(
    parameter int SUB_W       = 8,
    parameter int WIN_CYC     = 2303,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_stb,
    input  logic [SUB_W-1:0] frm_byte,
    input  logic             frm_is_sync,
    input  logic             rd_clk,
    output logic             win_n,
    output logic             blk_mark,
    output logic             rd_data
);
    logic win_open;
    logic shift_rise;

    subq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rd_clk),
        .rise     (shift_rise)
    );

    subq_win_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_stb  (frm_stb),
        .win_open (win_open)
    );

    subq_shifter #(.SUB_W(SUB_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_stb     (frm_stb),
        .frm_byte    (frm_byte),
        .frm_is_sync (frm_is_sync),
        .win_open    (win_open),
        .shift_rise  (shift_rise),
        .rd_data     (rd_data),
        .blk_mark    (blk_mark)
    );

    assign win_n = ~win_open;
endmodule

// File: tb/test_subq_port.sv
module test_subq_port;
    localparam int SUB_W = 8;
    localparam int WIN   = 120;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frm_stb = 1'b0;
    logic [SUB_W-1:0] frm_byte = '0;
    logic             frm_is_sync = 1'b0;
    logic             rd_clk = 1'b0;
    logic             win_n, blk_mark, rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        int    sel;   // 0 rd_data, 1 blk_mark, 2 win_n
        logic  exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    subq_port #(.SUB_W(SUB_W), .WIN_CYC(WIN), .SYNC_STAGES(2)) i_subq_port (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .frm_byte(frm_byte),
        .frm_is_sync(frm_is_sync), .rd_clk(rd_clk),
        .win_n(win_n), .blk_mark(blk_mark), .rd_data(rd_data)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic  got;
            it  = sb.pop_front();
            got = (it.sel == 0) ? rd_data : (it.sel == 1) ? blk_mark : win_n;
            check(int'(got), int'(it.exp), it.tag);
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic expect_out(input int sel, input logic v, input string tag);
        item_t it;
        it.sel = sel; it.exp = v; it.tag = tag;
        sb.push_back(it);
        cyc(1);
    endtask

    task automatic strobe(input logic [SUB_W-1:0] b, input logic s);
        frm_byte = b; frm_is_sync = s; frm_stb = 1'b1;
        cyc(1);
        frm_stb = 1'b0;
    endtask

    task automatic pulse();
        rd_clk = 1'b1; cyc(4);
        rd_clk = 1'b0; cyc(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        cyc(3);
        // R1 reset state
        expect_out(2, 1'b1, "R1 win_n");
        expect_out(0, 1'b0, "R1 rd_data");
        expect_out(1, 1'b0, "R1 blk_mark");
        rst_n = 1'b1;
        cyc(2);

        // R2 exact window length
        strobe(8'hA5, 1'b0);
        n = 0;
        while (win_n == 1'b0 && n < 1000) begin
            n++;
            cyc(1);
        end
        check(n, WIN, "R2 window length");
        expect_out(0, 1'b1, "R3 P of A5 first");
        expect_out(1, 1'b1, "R6 mark = P when not sync");

        // R8 pulses outside the window ignored
        pulse(); pulse(); pulse();
        expect_out(0, 1'b1, "R8 still P after closed-window pulses");
        expect_out(2, 1'b1, "R8 window stays closed");

        // R4 sequence order, R10 one step per pulse, R5 wrap
        strobe(8'h5C, 1'b0);
        expect_out(2, 1'b0, "R2 window open");
        expect_out(0, 1'b0, "R3 P of 5C");
        expect_out(1, 1'b0, "R6 mark = P (0)");
        for (int i = 1; i < SUB_W; i++) begin
            logic [SUB_W-1:0] b;
            b = 8'h5C;
            pulse();
            expect_out(0, b[SUB_W-1-i], $sformatf("R4 R10 bit %0d", i));
        end
        pulse();
        expect_out(0, 1'b0, "R5 wrap to P");
        pulse();
        expect_out(0, 1'b1, "R5 repeat Q");

        // R6 sync frame marking
        strobe(8'h00, 1'b1);
        expect_out(1, 1'b1, "R6 mark on sync frame");
        expect_out(0, 1'b0, "R6 data P of 00");
        strobe(8'h7F, 1'b0);
        expect_out(1, 1'b0, "R6 mark = P (0) of 7F");

        // R7 input changes without strobe
        frm_byte = 8'hFF; frm_is_sync = 1'b1;
        cyc(3);
        expect_out(1, 1'b0, "R7 mark unchanged");
        expect_out(0, 1'b0, "R7 data unchanged");
        pulse();
        expect_out(0, 1'b1, "R7 Q of latched 7F");

        // R9 restart mid-readout
        strobe(8'hC3, 1'b0);
        pulse(); pulse(); pulse();
        expect_out(0, 1'b0, "R9 C3 bit S");
        strobe(8'h3C, 1'b0);
        expect_out(0, 1'b0, "R9 restart at P of 3C");
        pulse();
        expect_out(0, 1'b0, "R9 Q of 3C");
        pulse();
        expect_out(0, 1'b1, "R9 R of 3C");

        while (sb.size() > 0) cyc(1);
        cyc(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule